// File: doc/BRIEF.md
# Spare Row and Column Address Remapper

This block sits on the address path between the system and a memory array built with a few extra rows and extra columns. After reset it takes in a repair image one bit at a time from a non-volatile fuse stream. The image says which row addresses and which column addresses are defective. It keeps this image for the rest of the session. It holds `ready` low until the whole image has arrived.

Once loaded, every access has its row and column compared against the stored defective addresses. A match steers the access to the spare assigned to that entry, so the system sees a complete, working address space. The physical address carries one extra top bit that selects the spare region of the array. The lower bits then give the spare index. The remap decision is purely combinational and adds no cycle of latency. Spare rows and spare columns are separate pools. The size of each pool and the address widths are parameters.

Top module: `spare_remap`

## Requirements
- R1: After reset `ready` is 0. It becomes 1 right after the clock edge that accepts the last image bit, and it stays 1 until the next reset.
- R2: The image is `N_SROW*(ROW_W+1) + N_SCOL*(COL_W+1)` bits long and is sent row entries first (entry 0 first), then column entries. Each entry is one valid bit followed by its address, least significant bit first. A bit is accepted on a rising edge where `fuse_vld` is 1.
- R3: While `ready` is 0, `phy_row` = {0, `row_addr`} and `phy_col` = {0, `col_addr`}: nothing is remapped.
- R4: When `row_addr` equals the address of a valid row entry k, `phy_row` = {1, k zero-extended to ROW_W bits}.
- R5: When `col_addr` equals the address of a valid column entry k and no row entry matches, `phy_col` = {1, k zero-extended to COL_W bits}.
- R6: When a row entry and a column entry both match, the row spare wins: `phy_row` shows the spare and `phy_col` = {0, `col_addr`}.
- R7: An entry whose valid bit is 0 never matches, even when the access address equals its stored address (address 0 included).
- R8: When several entries of the same kind match, the lowest index is used.
- R9: Fuse bits presented with `fuse_vld` low are ignored, and so is any bit offered after loading completes. Neither changes the mapping.
- R10: `phy_row` and `phy_col` follow `row_addr` and `col_addr` in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts image loading |
| fuse_vld | input | 1 | Fuse stream bit is valid this cycle |
| fuse_dat | input | 1 | Fuse stream data bit |
| ready | output | 1 | Repair image loaded; accesses may proceed |
| row_addr | input | ROW_W | Logical row address |
| col_addr | input | COL_W | Logical column address |
| phy_row | output | ROW_W+1 | Physical row; top bit selects the spare rows |
| phy_col | output | COL_W+1 | Physical column; top bit selects the spare columns |

## Verification
The physical row and column are due in the same cycle the logical address is applied. The driver changes the address just after a rising edge and queues the expected pair. The monitor pops the pair and compares it at the following falling edge, which is half a cycle later and still inside that address's cycle. `ready` is due one edge after the last accepted image bit. It is checked as low just before that edge and as high just after it. The fuse bits sent after loading, and the bits sent with `fuse_vld` low, are judged through the mapping seen on the remapped outputs afterwards.

// File: rtl/remap_pkg.sv
package remap_pkg;
  // Width of an index into a pool of n entries (at least one bit).
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fuse_loader.sv
module fuse_loader #(
  parameter int TOTAL = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fuse_vld,
  input  logic             fuse_dat,
  output logic             done,
  output logic [TOTAL-1:0] image
);
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] cnt;

  // First bit received ends up at image[0] after TOTAL shifts.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      done  <= 1'b0;
      image <= '0;
    end else if (!done && fuse_vld) begin
      image <= {fuse_dat, image[TOTAL-1:1]};
      cnt   <= cnt + 1'b1;
      if (cnt == CNT_W'(TOTAL - 1)) done <= 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(TOTAL)); // R2
  AST_IMAGE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(image)); // R9
endmodule

// File: rtl/entry_match.sv
module entry_match import remap_pkg::*; #(
  parameter int AW = 6,
  parameter int N  = 2,
  localparam int IW = idx_width(N),
  localparam int EW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [N*EW-1:0] table_i,
  input  logic [AW-1:0] key,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [N-1:0] match;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_ent
      // Entry layout: valid bit at the bottom, address above it.
      assign match[g] = en && table_i[g*EW] && (table_i[g*EW+1 +: AW] == key);
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
    hit |-> ((match & ((N'(1) << idx) - N'(1))) == '0)); // R8
  AST_HIT_IS_VALID: assert property (@(posedge clk) disable iff (rst)
    hit |-> table_i[idx*EW]); // R7
endmodule

// File: rtl/spare_remap.sv
module spare_remap import remap_pkg::*; #(
  parameter int ROW_W  = 6,
  parameter int COL_W  = 5,
  parameter int N_SROW = 2,
  parameter int N_SCOL = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fuse_vld,
  input  logic             fuse_dat,
  output logic             ready,
  input  logic [ROW_W-1:0] row_addr,
  input  logic [COL_W-1:0] col_addr,
  output logic [ROW_W:0]   phy_row,
  output logic [COL_W:0]   phy_col
);
  localparam int RIW    = idx_width(N_SROW);
  localparam int CIW    = idx_width(N_SCOL);
  localparam int ROW_TB = N_SROW * (ROW_W + 1);
  localparam int COL_TB = N_SCOL * (COL_W + 1);
  localparam int TOTAL  = ROW_TB + COL_TB;

  logic [TOTAL-1:0] image;
  logic             row_hit, col_hit;
  logic [RIW-1:0]   row_idx;
  logic [CIW-1:0]   col_idx;

  fuse_loader #(.TOTAL(TOTAL)) loader_i (
    .clk(clk), .rst(rst), .fuse_vld(fuse_vld), .fuse_dat(fuse_dat),
    .done(ready), .image(image)
  );

  entry_match #(.AW(ROW_W), .N(N_SROW)) row_cam_i (
    .clk(clk), .rst(rst), .en(ready), .table_i(image[ROW_TB-1:0]),
    .key(row_addr), .hit(row_hit), .idx(row_idx)
  );

  // Column spare is only considered when no row spare takes the access.
  entry_match #(.AW(COL_W), .N(N_SCOL)) col_cam_i (
    .clk(clk), .rst(rst), .en(ready && !row_hit), .table_i(image[TOTAL-1:ROW_TB]),
    .key(col_addr), .hit(col_hit), .idx(col_idx)
  );

  always_comb begin
    phy_row = row_hit ? {1'b1, ROW_W'(row_idx)} : {1'b0, row_addr};
    phy_col = col_hit ? {1'b1, COL_W'(col_idx)} : {1'b0, col_addr};
  end

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready); // R1
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (phy_row == {1'b0, row_addr}) && (phy_col == {1'b0, col_addr})); // R3
  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
    phy_row[ROW_W] |-> (phy_row[ROW_W-1:0] < ROW_W'(N_SROW))); // R4
  AST_COL_RANGE: assert property (@(posedge clk) disable iff (rst)
    phy_col[COL_W] |-> (phy_col[COL_W-1:0] < COL_W'(N_SCOL))); // R5
  AST_ROW_FIRST: assert property (@(posedge clk) disable iff (rst)
    phy_row[ROW_W] |-> !phy_col[COL_W]); // R6
endmodule

// File: tb/spare_remap_tb_top.sv
module spare_remap_tb_top;
  localparam int RW = 6, CW = 5, NR = 2, NC = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, fuse_vld = 1'b0, fuse_dat = 1'b0, ready;
  logic [RW-1:0] row_addr = '0;
  logic [CW-1:0] col_addr = '0;
  logic [RW:0]   phy_row;
  logic [CW:0]   phy_col;

  spare_remap #(.ROW_W(RW), .COL_W(CW), .N_SROW(NR), .N_SCOL(NC)) dut_i (
    .clk(clk), .rst(rst), .fuse_vld(fuse_vld), .fuse_dat(fuse_dat), .ready(ready),
    .row_addr(row_addr), .col_addr(col_addr), .phy_row(phy_row), .phy_col(phy_col)
  );

  int n_run = 0, n_fail = 0;
  typedef struct { logic [RW:0] r; logic [CW:0] c; string tag; } exp_t;
  exp_t q[$];

  bit            rv[NR], cv[NC];
  logic [RW-1:0] ra[NR];
  logic [CW-1:0] ca[NC];
  bit            mdl_rdy;

  function automatic exp_t model(input logic [RW-1:0] r, input logic [CW-1:0] c);
    exp_t e;
    bit rh;
    rh  = 1'b0;
    e.r = {1'b0, r};
    e.c = {1'b0, c};
    if (mdl_rdy) begin
      for (int i = NR - 1; i >= 0; i--)
        if (rv[i] && ra[i] == r) begin e.r = {1'b1, RW'(i)}; rh = 1'b1; end
      if (!rh)
        for (int i = NC - 1; i >= 0; i--)
          if (cv[i] && ca[i] == c) e.c = {1'b1, CW'(i)};
    end
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: apply an access, queue the result due in this same cycle (R10).
  task automatic drive(input logic [RW-1:0] r, input logic [CW-1:0] c, input string tag);
    exp_t e;
    @(posedge clk); #1;
    row_addr = r;
    col_addr = c;
    e = model(r, c);
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare at the falling edge inside the access cycle.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (phy_row !== e.r || phy_col !== e.c) begin
        n_fail++;
        $display("FAIL %s: actual row %h col %h expected row %h col %h",
                 e.tag, phy_row, phy_col, e.r, e.c);
      end
    end
  end

  task automatic send_bit(input bit b);
    @(posedge clk); #1;
    fuse_vld = 1'b1;
    fuse_dat = b;
  endtask

  task automatic gap(input bit junk);
    @(posedge clk); #1;
    fuse_vld = 1'b0;
    fuse_dat = junk;
  endtask

  task automatic do_reset();
    rst = 1'b1; fuse_vld = 1'b0; mdl_rdy = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #2 chk(ready == 1'b0, "R1 ready low after reset", ready, 0);
  endtask

  // R2 image order; R9 gaps carry inverted junk with fuse_vld low.
  task automatic load_image();
    int n;
    n = 0;
    for (int i = 0; i < NR; i++) begin
      send_bit(rv[i]);
      for (int b = 0; b < RW; b++) begin
        send_bit(ra[i][b]);
        n++;
        if (n % 5 == 0) begin
          gap(~ra[i][b]);
          chk(phy_row == {1'b0, row_addr}, "R3 pass-through while loading",
              int'(phy_row), int'({1'b0, row_addr}));
        end
      end
    end
    for (int i = 0; i < NC; i++) begin
      send_bit(cv[i]);
      for (int b = 0; b < CW; b++) begin
        send_bit(ca[i][b]);
        n++;
        if (n % 5 == 0) gap(~ca[i][b]);
      end
    end
    chk(ready == 1'b0, "R1 ready low before last bit", ready, 0);
    gap(1'b0);
    chk(ready == 1'b1, "R1 ready high after last bit", ready, 1);
    mdl_rdy = 1'b1;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // Image 1: rows 12 and 40 valid, column 0 invalid at address 0, column 1 valid at 7.
    rv[0] = 1; ra[0] = 12; rv[1] = 1; ra[1] = 40;
    cv[0] = 0; ca[0] = 0;  cv[1] = 1; ca[1] = 7;
    do_reset();
    drive(12, 7, "R3 no remap before load");
    load_image();
    drive(12, 20, "R4 row entry 0");
    drive(40, 3,  "R4 row entry 1");
    drive(5, 7,   "R5 column entry 1");
    drive(12, 7,  "R6 row wins over column");
    drive(5, 0,   "R7 invalid column entry at 0");
    drive(0, 0,   "R7 zero address no match");
    drive(41, 6,  "R10 plain pass-through");
    drive(40, 7,  "R10 back-to-back change");
    // R9: stream ones after loading completed.
    for (int k = 0; k < 12; k++) send_bit(1'b1);
    gap(1'b0);
    chk(ready == 1'b1, "R1 ready stays high", ready, 1);
    drive(12, 7, "R9 mapping kept after extra bits");
    drive(63, 31, "R9 all-ones address still plain");
    drive(5, 7,   "R9 column mapping kept");

    // Image 2: duplicate entries for priority.
    rv[0] = 1; ra[0] = 9; rv[1] = 1; ra[1] = 9;
    cv[0] = 1; ca[0] = 3; cv[1] = 1; ca[1] = 3;
    do_reset();
    load_image();
    drive(9, 1, "R8 lowest row entry");
    drive(4, 3, "R8 lowest column entry");
    drive(9, 3, "R6 row wins with duplicates");
    repeat (2) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule